// File: doc/BRIEF.md
# Serial-Bus Sampling Track/Hold Sequencer

This block sits beside a two-wire serial slave inside a converter chip and controls the sampling front end. It oversamples the bus clock and data lines with the system clock and detects start and stop conditions and clock edges. It counts the clock pulses since the last start, and from these it drives the sample capacitor's track and hold switches and starts the converter.

Two pacing modes are supported. In internal mode, tracking begins while the read/write bit is clocked in. The sample is frozen when the clock falls at the end of the address acknowledge, and the block asks for the bus clock to be held low until the converter reports completion. In external mode, tracking begins on the same edge, but the sample is frozen on the second clock pulse of the first result byte. The next twelve bus clock rising edges then each produce a one-cycle bit strobe that paces the converter. A start or stop condition seen while a sequence is in progress abandons the sequence.

Top module: `tsq_sequencer`

## Requirements
- R1: After reset, trackEn, holdEn, convStart, stretchEn and bitStrobe are all 0.
- R2: With modeExt=0, trackEn goes to 1 on the 8th SCL rising edge after a START, provided addrMatch=1 and SDA=1 (read) on that edge.
- R3: With modeExt=0, on the falling SCL edge of the 9th pulse after a START, trackEn drops, holdEn and stretchEn rise, and convStart pulses exactly once.
- R4: While stretchEn=1, a convDone of 1 clears stretchEn and holdEn on the next system clock, and the block returns to idle.
- R5: With modeExt=1, trackEn goes to 1 on the 8th SCL rising edge after a START, under the same addrMatch=1 and SDA=1 condition as R2.
- R6: With modeExt=1, on the 11th SCL rising edge after a START (the 2nd pulse of the first result byte), trackEn drops, holdEn rises and convStart pulses exactly once. stretchEn stays 0.
- R7: With modeExt=1, after hold begins, exactly 12 bitStrobe pulses are produced, one for each following SCL rising edge. After the 12th pulse, holdEn drops and further SCL edges produce no strobes.
- R8: If addrMatch=0, or SDA=0 (write) on the 8th rising edge, then trackEn, holdEn and convStart stay 0 for that transfer.
- R9: A START (SDA falling while SCL high) or a STOP (SDA rising while SCL high) during track or hold returns the block to idle. A START also restarts the pulse count, so the next address byte is counted from it.
- R10: trackEn and holdEn are never 1 at the same time.
- R11: convStart and bitStrobe last one system clock each. stretchEn is 1 only while holdEn is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversampling the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| addrMatch | input | 1 | Slave address comparison result, valid by the 8th rising edge |
| modeExt | input | 1 | 1 selects external (bus-clock paced) conversion, 0 internal |
| convDone | input | 1 | Converter finished (internal mode) |
| trackEn | output | 1 | Sample switch in track position |
| holdEn | output | 1 | Sample switch in hold position |
| convStart | output | 1 | One-cycle pulse when hold begins |
| stretchEn | output | 1 | Request to hold the bus clock low |
| bitStrobe | output | 1 | One-cycle pulse per conversion bit in external mode |

## Verification
A table drives complete transfers through every combination of mode, address match and read/write direction. This separates the transfers that must sample from those that must stay idle, and the internal-mode outcome (clock stretch ended by convDone) from the external-mode outcome (twelve strobes). External transfers run sixteen clock pulses past the hold edge, so a strobe count that does not stop at twelve is caught. Directed tests then place a STOP in the middle of tracking and a repeated START in the middle of hold. The bench confirms that the START is followed by a freshly counted address byte, which tells a real restart apart from a mere drop to idle.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

  // Bus events produced by the datapath, one system clock wide.
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startDet;
    logic stopDet;
    logic sdaLvl;
  } busEvt_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic convCntClr;
    logic convCntInc;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ADDR,
    SQ_TRK_INT,
    SQ_HLD_INT,
    SQ_TRK_EXT,
    SQ_HLD_EXT
  } seqState_t;

endpackage

// File: rtl/tsq_bus_datapath.sv
module tsq_bus_datapath
  import tsq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CONV_CYCLES = 12,
  parameter int BIT_CNT_W   = 4,
  parameter int CONV_CNT_W  = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  input  dpStrobe_t             strobe,
  output busEvt_t               evt,
  output logic [BIT_CNT_W-1:0]  bitCnt,
  output logic                  lastConvBit
);

  localparam logic [BIT_CNT_W-1:0]  BIT_CNT_MAX = '1;
  localparam logic [CONV_CNT_W-1:0] CONV_LAST   = CONV_CNT_W'(CONV_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sclSync;
  logic [SYNC_STAGES-1:0] sdaSync;
  logic                   sclPrev;
  logic                   sdaPrev;
  logic                   sclNow;
  logic                   sdaNow;
  logic [CONV_CNT_W-1:0]  convCnt;

  // Both lines idle high, so the synchronizers reset to 1.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclNow = sclSync[SYNC_STAGES-1];
  assign sdaNow = sdaSync[SYNC_STAGES-1];

  always_comb begin
    evt.sclRise  = sclNow & ~sclPrev;
    evt.sclFall  = ~sclNow & sclPrev;
    evt.startDet = sclNow & sclPrev & sdaPrev & ~sdaNow;
    evt.stopDet  = sclNow & sclPrev & ~sdaPrev & sdaNow;
    evt.sdaLvl   = sdaNow;
  end

  // Rising edges since the last START, saturating.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (evt.startDet) begin
      bitCnt <= '0;
    end else if (evt.sclRise && bitCnt != BIT_CNT_MAX) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  // Conversion bit counter for bus-paced conversion.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convCnt <= '0;
    end else if (strobe.convCntClr) begin
      convCnt <= '0;
    end else if (strobe.convCntInc) begin
      convCnt <= convCnt + 1'b1;
    end
  end

  assign lastConvBit = (convCnt == CONV_LAST);

endmodule

// File: rtl/tsq_control.sv
module tsq_control
  import tsq_pkg::*;
#(
  parameter int ADDR_BITS = 8,
  parameter int BIT_CNT_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  busEvt_t               evt,
  input  logic [BIT_CNT_W-1:0]  bitCnt,
  input  logic                  lastConvBit,
  input  logic                  addrMatch,
  input  logic                  modeExt,
  input  logic                  convDone,
  output dpStrobe_t             strobe,
  output logic                  trackEn,
  output logic                  holdEn,
  output logic                  convStart,
  output logic                  stretchEn,
  output logic                  bitStrobe
);

  // Count values seen before the edge is added.
  localparam logic [BIT_CNT_W-1:0] RW_EDGE   = BIT_CNT_W'(ADDR_BITS - 1);
  localparam logic [BIT_CNT_W-1:0] ACK_PULSE = BIT_CNT_W'(ADDR_BITS + 1);
  localparam logic [BIT_CNT_W-1:0] EXT_HOLD  = BIT_CNT_W'(ADDR_BITS + 2);

  seqState_t state;
  seqState_t stateNxt;
  logic      goStart;
  logic      goStrobe;

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    goStart  = 1'b0;
    goStrobe = 1'b0;
    if (evt.startDet) begin
      stateNxt = SQ_ADDR;
    end else if (evt.stopDet) begin
      stateNxt = SQ_IDLE;
    end else begin
      unique case (state)
        SQ_ADDR: begin
          if (evt.sclRise && bitCnt == RW_EDGE) begin
            if (addrMatch && evt.sdaLvl) begin
              stateNxt = modeExt ? SQ_TRK_EXT : SQ_TRK_INT;
            end else begin
              stateNxt = SQ_IDLE;
            end
          end
        end
        SQ_TRK_INT: begin
          if (evt.sclFall && bitCnt == ACK_PULSE) begin
            stateNxt = SQ_HLD_INT;
            goStart  = 1'b1;
          end
        end
        SQ_HLD_INT: begin
          if (convDone) stateNxt = SQ_IDLE;
        end
        SQ_TRK_EXT: begin
          if (evt.sclRise && bitCnt == EXT_HOLD) begin
            stateNxt          = SQ_HLD_EXT;
            goStart           = 1'b1;
            strobe.convCntClr = 1'b1;
          end
        end
        SQ_HLD_EXT: begin
          if (evt.sclRise) begin
            goStrobe          = 1'b1;
            strobe.convCntInc = 1'b1;
            if (lastConvBit) stateNxt = SQ_IDLE;
          end
        end
        default: stateNxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= SQ_IDLE;
      convStart <= 1'b0;
      bitStrobe <= 1'b0;
    end else begin
      state     <= stateNxt;
      convStart <= goStart;
      bitStrobe <= goStrobe;
    end
  end

  assign trackEn   = (state == SQ_TRK_INT) || (state == SQ_TRK_EXT);
  assign holdEn    = (state == SQ_HLD_INT) || (state == SQ_HLD_EXT);
  assign stretchEn = (state == SQ_HLD_INT);

endmodule

// File: rtl/tsq_sequencer.sv
module tsq_sequencer
  import tsq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_BITS   = 8,
  parameter int CONV_CYCLES = 12
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic addrMatch,
  input  logic modeExt,
  input  logic convDone,
  output logic trackEn,
  output logic holdEn,
  output logic convStart,
  output logic stretchEn,
  output logic bitStrobe
);

  localparam int BIT_CNT_W  = $clog2(ADDR_BITS + 4);
  localparam int CONV_CNT_W = $clog2(CONV_CYCLES + 1);

  busEvt_t              evt;
  dpStrobe_t            strobe;
  logic [BIT_CNT_W-1:0] bitCnt;
  logic                 lastConvBit;

  tsq_bus_datapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .CONV_CYCLES (CONV_CYCLES),
    .BIT_CNT_W   (BIT_CNT_W),
    .CONV_CNT_W  (CONV_CNT_W)
  ) datapath_i (
    .clk         (clk),
    .rstN        (rstN),
    .sclIn       (sclIn),
    .sdaIn       (sdaIn),
    .strobe      (strobe),
    .evt         (evt),
    .bitCnt      (bitCnt),
    .lastConvBit (lastConvBit)
  );

  tsq_control #(
    .ADDR_BITS (ADDR_BITS),
    .BIT_CNT_W (BIT_CNT_W)
  ) control_i (
    .clk         (clk),
    .rstN        (rstN),
    .evt         (evt),
    .bitCnt      (bitCnt),
    .lastConvBit (lastConvBit),
    .addrMatch   (addrMatch),
    .modeExt     (modeExt),
    .convDone    (convDone),
    .strobe      (strobe),
    .trackEn     (trackEn),
    .holdEn      (holdEn),
    .convStart   (convStart),
    .stretchEn   (stretchEn),
    .bitStrobe   (bitStrobe)
  );

endmodule

// File: rtl/tsq_checker.sv
module tsq_checker (
  input logic clk,
  input logic rstN,
  input logic convDone,
  input logic trackEn,
  input logic holdEn,
  input logic convStart,
  input logic stretchEn,
  input logic bitStrobe
);

  p_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(trackEn && holdEn));

  p_start_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  p_strobe_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    bitStrobe |=> !bitStrobe);

  p_stretch_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    stretchEn |-> holdEn);

  // Hold entry comes with the start pulse (R3, R6).
  p_hold_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdEn) |-> convStart);

  p_done_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stretchEn && convDone) |=> (!stretchEn && !holdEn));

  p_strobe_after_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    bitStrobe |-> $past(holdEn));

endmodule

bind tsq_sequencer tsq_checker checker_i (
  .clk       (clk),
  .rstN      (rstN),
  .convDone  (convDone),
  .trackEn   (trackEn),
  .holdEn    (holdEn),
  .convStart (convStart),
  .stretchEn (stretchEn),
  .bitStrobe (bitStrobe)
);

// File: tb/tsq_sequencer_tb_top.sv
module tsq_sequencer_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclIn = 1'b1;
  logic sdaIn = 1'b1;
  logic addrMatch = 1'b0;
  logic modeExt = 1'b0;
  logic convDone = 1'b0;
  logic trackEn, holdEn, convStart, stretchEn, bitStrobe;

  int nVec = 0;
  int nFail = 0;
  int startCnt = 0;
  int strobeCnt = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  tsq_sequencer dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrMatch(addrMatch), .modeExt(modeExt), .convDone(convDone),
    .trackEn(trackEn), .holdEn(holdEn), .convStart(convStart),
    .stretchEn(stretchEn), .bitStrobe(bitStrobe)
  );

  always @(posedge clk) begin
    if (convStart === 1'b1) startCnt <= startCnt + 1;
    if (bitStrobe === 1'b1) strobeCnt <= strobeCnt + 1;
  end

  // Fields: [8] modeExt [7] addrMatch [6] rw [5] expTrack [4] expHold [3:0] expStrobes
  localparam logic [8:0] VEC [6] = '{
    {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd0},
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0},
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0},
    {1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'd12},
    {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0},
    {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0}
  };
  localparam logic [6:0] ADDR7 = 7'b0110110;

  task automatic chk(input string req, input int act, input int exp);
    nVec++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitHigh(input logic b);
    sdaIn = b;
    waitClk(2);
    sclIn = 1'b1;
    waitClk(6);
  endtask

  task automatic sclDown();
    sclIn = 1'b0;
    waitClk(6);
  endtask

  task automatic busStart();
    sdaIn = 1'b1;
    waitClk(2);
    sclIn = 1'b1;
    waitClk(6);
    sdaIn = 1'b0;
    waitClk(6);
    sclDown();
  endtask

  task automatic busStop();
    sdaIn = 1'b0;
    waitClk(2);
    sclIn = 1'b1;
    waitClk(6);
    sdaIn = 1'b1;
    waitClk(6);
  endtask

  task automatic sendAddr7();
    for (int i = 6; i >= 0; i--) begin
      bitHigh(ADDR7[i]);
      sclDown();
    end
  endtask

  // Complete internal-mode sampling after the address bits (R2, R3, R4).
  task automatic internalTail(input string tag);
    int s0;
    bitHigh(1'b1);
    chk({tag, " R2 track on 8th rise"}, int'(trackEn), 1);
    sclDown();
    s0 = startCnt;
    bitHigh(1'b0);
    sclDown();
    chk({tag, " R3 hold after ack fall"}, int'(holdEn), 1);
    chk({tag, " R3 stretch after ack fall"}, int'(stretchEn), 1);
    chk({tag, " R3 single convStart"}, startCnt - s0, 1);
    convDone = 1'b1;
    waitClk(1);
    chk({tag, " R4 stretch released"}, int'(stretchEn), 0);
    chk({tag, " R4 hold released"}, int'(holdEn), 0);
    convDone = 1'b0;
    waitClk(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++;
      nVec++;
      $display("FAIL watchdog (all requirements): actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  end

  initial begin
    waitClk(3);
    // R1: reset state
    chk("R1 trackEn", int'(trackEn), 0);
    chk("R1 holdEn", int'(holdEn), 0);
    chk("R1 stretchEn", int'(stretchEn), 0);
    chk("R1 convStart/bitStrobe", int'(convStart) + int'(bitStrobe), 0);
    rstN = 1'b1;
    waitClk(4);
    chk("R1 idle after release", int'(trackEn) + int'(holdEn), 0);

    // Table-driven transfers (R2, R3, R5, R6, R7, R8)
    for (int v = 0; v < 6; v++) begin
      int s0;
      int b0;
      logic isExt, isMatch, rw, eTrk, eHld;
      int eStr;
      isExt   = VEC[v][8];
      isMatch = VEC[v][7];
      rw      = VEC[v][6];
      eTrk    = VEC[v][5];
      eHld    = VEC[v][4];
      eStr    = int'(VEC[v][3:0]);
      modeExt   = isExt;
      addrMatch = isMatch;
      s0 = startCnt;
      b0 = strobeCnt;
      busStart();
      sendAddr7();
      bitHigh(rw);
      chk($sformatf("vec%0d R2/R5/R8 track", v), int'(trackEn), int'(eTrk));
      sclDown();
      bitHigh(1'b0);
      sclDown();
      if (!isExt) begin
        chk($sformatf("vec%0d R3/R8 hold", v), int'(holdEn), int'(eHld));
        chk($sformatf("vec%0d R3/R8 stretch", v), int'(stretchEn), int'(eHld));
        chk($sformatf("vec%0d R3/R8 convStart", v), startCnt - s0, int'(eHld));
        if (eHld) begin
          convDone = 1'b1;
          waitClk(1);
          chk($sformatf("vec%0d R4 release", v), int'(stretchEn) + int'(holdEn), 0);
          convDone = 1'b0;
          waitClk(2);
        end
      end else begin
        bitHigh(1'b1);
        sclDown();
        bitHigh(1'b1);
        chk($sformatf("vec%0d R6/R8 hold", v), int'(holdEn), int'(eHld));
        chk($sformatf("vec%0d R6 no track in hold", v), int'(trackEn), 0);
        chk($sformatf("vec%0d R6 no stretch", v), int'(stretchEn), 0);
        chk($sformatf("vec%0d R6/R8 convStart", v), startCnt - s0, int'(eHld));
        sclDown();
        for (int p = 0; p < 16; p++) begin
          bitHigh(1'b1);
          sclDown();
        end
        chk($sformatf("vec%0d R7 strobe count", v), strobeCnt - b0, eStr);
        chk($sformatf("vec%0d R7 idle after strobes", v), int'(holdEn), 0);
      end
      busStop();
      waitClk(4);
    end

    // R9: STOP while tracking in external mode
    modeExt = 1'b1;
    addrMatch = 1'b1;
    busStart();
    sendAddr7();
    bitHigh(1'b1);
    chk("R5 track before stop", int'(trackEn), 1);
    sclDown();
    busStop();
    chk("R9 stop aborts track", int'(trackEn) + int'(holdEn), 0);
    waitClk(4);

    // R9: repeated START during external hold, then a fresh internal transfer
    begin
      int b0;
      busStart();
      sendAddr7();
      bitHigh(1'b1);
      sclDown();
      bitHigh(1'b0);
      sclDown();
      bitHigh(1'b1);
      sclDown();
      bitHigh(1'b1);
      chk("R6 hold before restart", int'(holdEn), 1);
      sclDown();
      busStart();
      chk("R9 start aborts hold", int'(holdEn) + int'(trackEn), 0);
      b0 = strobeCnt;
      modeExt = 1'b0;
      sendAddr7();
      chk("R9 no strobes after abort", strobeCnt - b0, 0);
      internalTail("restart");
      busStop();
      waitClk(4);
    end

    // R8: address mismatch in internal mode leaves outputs quiet on later pulses
    addrMatch = 1'b0;
    busStart();
    sendAddr7();
    bitHigh(1'b1);
    sclDown();
    for (int p = 0; p < 4; p++) begin
      bitHigh(1'b0);
      sclDown();
    end
    chk("R8 quiet after mismatch", int'(trackEn) + int'(holdEn) + int'(stretchEn), 0);
    busStop();

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

endmodule